// File: doc/BRIEF.md
# PSRAM Low-Power Mode Sequencer

This block is the control state machine inside a pseudo-static RAM that picks between normal operation, a data-retaining partial-refresh sleep, and a deep power-down that destroys the array contents. The choice depends on two things: a low-active sleep pin and one configuration bit. When the bit is 1, pulling the pin low selects partial refresh. When the bit is 0, a low level that lasts long enough selects deep power-down.

Leaving deep power-down starts an initialization window. Accesses stay blocked for the whole window and a busy flag is raised. A pulse from the register-load detector marks a completed software configuration load. That pulse locks the part into partial-refresh operation from then on, and the load path can never lead into deep power-down.

All intervals are counted in clock cycles. One counter times both the entry qualification and the initialization window.

Top module: `psram_lp_seq`

## Requirements
- R1: After reset the state code is 0 (normal), `refreshEn` is 1, `dataValid` is 0, `busy` is 0 and `accessAllow` equals `sleepN`.
- R2: In normal state, or in partial-refresh state with `sleepN` high, `accessAllow` is 1, and a `writeReq` sets `dataValid` on the next edge. A `writeReq` while `accessAllow` is 0 leaves `dataValid` unchanged.
- R3: With `cfgSleepBit` at 0 and no lock, `sleepN` low on a rising edge in normal state moves to the qualify state (code 1). If it is sampled low on ENTRY_CYC+1 consecutive edges, the block enters deep power-down (code 2) on the last of those edges. If it is sampled low on only ENTRY_CYC edges, the block returns to normal when `sleepN` is sampled high.
- R4: In deep power-down, `refreshEn` is 0 and `accessAllow` is 0. `dataValid` is 0 from the entry edge onward, and writes are ignored.
- R5: `sleepN` sampled high in deep power-down enters the initialization state (code 3). The block stays there for exactly INIT_CYC cycles with `busy` at 1, `refreshEn` at 1 and `accessAllow` at 0, then returns to normal. `dataValid` stays 0 until a new write.
- R6: With `cfgSleepBit` at 1, `sleepN` low in normal state enters partial refresh (code 4) on the next edge. The block never enters deep power-down there, however long the pin stays low. `refreshEn` and `dataValid` are kept. `sleepN` high returns to normal on the next edge with `busy` at 0.
- R7: After a `regLoadDone` pulse, the block goes to partial refresh and stays there whatever the level of `sleepN`. It never enters deep power-down again. `accessAllow` follows `sleepN`.
- R8: If `cfgSleepBit` rises during qualification while `sleepN` is still low, the block moves to partial refresh instead of deep power-down.
- R9: `sleepN` low during initialization has no effect until the window ends. The block then enters normal state and starts a fresh qualification.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| sleepN | input | 1 | Low-active sleep pin |
| cfgSleepBit | input | 1 | Configuration sleep bit: 1 selects partial refresh, 0 allows deep power-down |
| regLoadDone | input | 1 | One-cycle pulse marking a completed software register load |
| writeReq | input | 1 | Write request to the array |
| refreshEn | output | 1 | Refresh engine enable |
| accessAllow | output | 1 | 1 when a read or write is accepted, 0 when it is ignored |
| dataValid | output | 1 | Array contents are valid |
| busy | output | 1 | Initialization window in progress |
| stateCode | output | 3 | 0 normal, 1 qualify, 2 deep power-down, 3 init, 4 partial refresh |

## Verification
The bench drives low pulses of exactly ENTRY_CYC edges and of ENTRY_CYC+1 edges. An off-by-one in the qualification count would either enter deep power-down on a short glitch or need one extra cycle to get there.

It raises the configuration bit in the middle of a qualification. It also holds the pin low across the end of the initialization window. A design that ignored the bit would destroy data that should have been kept, and one that restarted the window early would release accesses too soon.

After the register-load pulse, long low levels must not reach deep power-down. A design that forgot the lock would clear `dataValid` at that point.

// File: rtl/psram_lp_pkg.sv
package psram_lp_pkg;
  typedef enum logic [2:0] {
    ST_NORMAL = 3'd0,
    ST_QUAL   = 3'd1,
    ST_DPD    = 3'd2,
    ST_INIT   = 3'd3,
    ST_PAR    = 3'd4
  } lpState_e;

  typedef struct packed {
    logic cntClr;
    logic cntRun;
    logic dataKill;
  } lpStrobe_t;
endpackage

// File: rtl/lp_timer.sv
module lp_timer
  import psram_lp_pkg::*;
#(
  parameter int ENTRY_CYC = 1250,
  parameter int INIT_CYC  = 18750
) (
  input  logic      clk,
  input  logic      rstN,
  input  lpStrobe_t strobe,
  input  logic      writeOk,
  input  logic      regLoadDone,
  output logic      entryHit,
  output logic      initHit,
  output logic      dataValid,
  output logic      parLocked
);
  localparam int CNT_MAX = (ENTRY_CYC > INIT_CYC) ? ENTRY_CYC : INIT_CYC;
  localparam int CW = $clog2(CNT_MAX + 1);
  localparam logic [CW-1:0] ENTRY_LAST = CW'(ENTRY_CYC - 1);
  localparam logic [CW-1:0] INIT_LAST  = CW'(INIT_CYC - 1);
  localparam logic [CW-1:0] CNT_TOP    = CW'(CNT_MAX);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt <= '0;
    end else if (strobe.cntClr) begin
      cnt <= '0;
    end else if (strobe.cntRun && cnt != CNT_TOP) begin
      cnt <= cnt + 1'b1;
    end
  end

  assign entryHit = (cnt == ENTRY_LAST);
  assign initHit  = (cnt == INIT_LAST);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dataValid <= 1'b0;
    end else if (strobe.dataKill) begin
      dataValid <= 1'b0;
    end else if (writeOk) begin
      dataValid <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      parLocked <= 1'b0;
    end else if (regLoadDone) begin
      parLocked <= 1'b1;
    end
  end

  // R3
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    cnt <= CNT_TOP);

  // R4
  kill_clears_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.dataKill |=> !dataValid);
endmodule

// File: rtl/lp_ctrl.sv
module lp_ctrl
  import psram_lp_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      sleepN,
  input  logic      cfgSleepBit,
  input  logic      parLocked,
  input  logic      entryHit,
  input  logic      initHit,
  output lpState_e  state,
  output lpStrobe_t strobe,
  output logic      refreshEn,
  output logic      accessAllow,
  output logic      busy
);
  lpState_e nextState;

  always_comb begin
    nextState = state;
    strobe    = '0;
    unique case (state)
      ST_NORMAL: begin
        if (parLocked) begin
          nextState = ST_PAR;
        end else if (!sleepN) begin
          if (cfgSleepBit) begin
            nextState = ST_PAR;
          end else begin
            nextState     = ST_QUAL;
            strobe.cntClr = 1'b1;
          end
        end
      end
      ST_QUAL: begin
        strobe.cntRun = 1'b1;
        if (sleepN) begin
          nextState = ST_NORMAL;
        end else if (cfgSleepBit || parLocked) begin
          nextState = ST_PAR;
        end else if (entryHit) begin
          nextState       = ST_DPD;
          strobe.dataKill = 1'b1;
        end
      end
      ST_DPD: begin
        if (sleepN) begin
          nextState     = ST_INIT;
          strobe.cntClr = 1'b1;
        end
      end
      ST_INIT: begin
        strobe.cntRun = 1'b1;
        if (initHit) begin
          nextState = parLocked ? ST_PAR : ST_NORMAL;
        end
      end
      ST_PAR: begin
        if (sleepN && !parLocked) begin
          nextState = ST_NORMAL;
        end
      end
      default: nextState = ST_NORMAL;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_NORMAL;
    end else begin
      state <= nextState;
    end
  end

  assign refreshEn   = (state != ST_DPD);
  assign busy        = (state == ST_INIT);
  assign accessAllow = sleepN && (state == ST_NORMAL || state == ST_PAR);

  // R5
  dpd_exit_init_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(state) == ST_DPD && state != ST_DPD) |-> state == ST_INIT);

  // R6
  par_no_dpd_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(state) == ST_PAR |-> state != ST_DPD);
endmodule

// File: rtl/psram_lp_seq.sv
module psram_lp_seq
  import psram_lp_pkg::*;
#(
  parameter int ENTRY_CYC = 1250,
  parameter int INIT_CYC  = 18750
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sleepN,
  input  logic       cfgSleepBit,
  input  logic       regLoadDone,
  input  logic       writeReq,
  output logic       refreshEn,
  output logic       accessAllow,
  output logic       dataValid,
  output logic       busy,
  output logic [2:0] stateCode
);
  lpState_e  state;
  lpStrobe_t strobe;
  logic      entryHit;
  logic      initHit;
  logic      parLocked;
  logic      writeOk;

  assign writeOk   = writeReq && accessAllow;
  assign stateCode = state;

  lp_ctrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .sleepN      (sleepN),
    .cfgSleepBit (cfgSleepBit),
    .parLocked   (parLocked),
    .entryHit    (entryHit),
    .initHit     (initHit),
    .state       (state),
    .strobe      (strobe),
    .refreshEn   (refreshEn),
    .accessAllow (accessAllow),
    .busy        (busy)
  );

  lp_timer #(
    .ENTRY_CYC (ENTRY_CYC),
    .INIT_CYC  (INIT_CYC)
  ) u_timer (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .writeOk     (writeOk),
    .regLoadDone (regLoadDone),
    .entryHit    (entryHit),
    .initHit     (initHit),
    .dataValid   (dataValid),
    .parLocked   (parLocked)
  );

  // R4
  dpd_data_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    state == ST_DPD |-> !dataValid);

  // R3
  dpd_entry_qual_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_DPD && $past(state) != ST_DPD) |-> ($past(entryHit) && !$past(cfgSleepBit)));

  // R7
  lock_no_dpd_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_DPD && $past(state) != ST_DPD) |-> !$past(parLocked));

  // R5
  init_exit_count_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(state) == ST_INIT && state != ST_INIT) |-> $past(initHit));

  // R6
  par_keeps_data_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(state) == ST_PAR && $past(dataValid)) |-> dataValid);
endmodule

// File: tb/psram_lp_seq_tb.sv
module psram_lp_seq_tb;
  localparam int ENTRY = 20;
  localparam int INIT  = 50;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sleepN = 1'b1;
  logic cfgSleepBit = 1'b0;
  logic regLoadDone = 1'b0;
  logic writeReq = 1'b0;
  logic refreshEn, accessAllow, dataValid, busy;
  logic [2:0] stateCode;

  int testsRun = 0;
  int testsFailed = 0;
  int cycles = 0;
  string curReq = "R1";

  always #4 clk = ~clk;

  psram_lp_seq #(.ENTRY_CYC(ENTRY), .INIT_CYC(INIT)) u_dut (
    .clk(clk), .rstN(rstN), .sleepN(sleepN), .cfgSleepBit(cfgSleepBit),
    .regLoadDone(regLoadDone), .writeReq(writeReq), .refreshEn(refreshEn),
    .accessAllow(accessAllow), .dataValid(dataValid), .busy(busy),
    .stateCode(stateCode)
  );

  // reference model built from the requirements
  logic [2:0] mState;
  int         mCnt;
  logic       mValid;
  logic       mLocked;

  function automatic logic expAllow(logic [2:0] s, logic sn);
    return sn && (s == 3'd0 || s == 3'd4);
  endfunction

  function automatic logic [6:0] expOut(logic [2:0] s, logic sn, logic v);
    return {s, (s != 3'd2), expAllow(s, sn), v, (s == 3'd3)};
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mState <= 3'd0; mCnt <= 0; mValid <= 1'b0; mLocked <= 1'b0;
    end else begin
      if (writeReq && expAllow(mState, sleepN)) mValid <= 1'b1;
      if (regLoadDone) mLocked <= 1'b1;
      case (mState)
        3'd0: if (mLocked) mState <= 3'd4;
              else if (!sleepN) begin
                if (cfgSleepBit) mState <= 3'd4;
                else begin mState <= 3'd1; mCnt <= 0; end
              end
        3'd1: if (sleepN) mState <= 3'd0;
              else if (cfgSleepBit || mLocked) mState <= 3'd4;
              else if (mCnt == ENTRY - 1) begin mState <= 3'd2; mValid <= 1'b0; end
              else mCnt <= mCnt + 1;
        3'd2: if (sleepN) begin mState <= 3'd3; mCnt <= 0; end
        3'd3: if (mCnt == INIT - 1) mState <= mLocked ? 3'd4 : 3'd0;
              else mCnt <= mCnt + 1;
        default: if (sleepN && !mLocked) mState <= 3'd0;
      endcase
    end
  end

  task automatic check(string req, logic [6:0] act, logic [6:0] exp);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s: outputs {st,ref,acc,val,busy} actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic step(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      check(curReq, {stateCode, refreshEn, accessAllow, dataValid, busy},
            expOut(mState, sleepN, mValid));
    end
  endtask

  task automatic expectState(string req, logic [2:0] s);
    testsRun++;
    if (stateCode !== s) begin
      testsFailed++;
      $display("FAIL %s: stateCode actual %0d expected %0d", req, stateCode, s);
    end
  endtask

  task automatic expectBit(string req, logic act, logic exp);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      testsRun++;
      testsFailed++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    curReq = "R1";
    step(1);
    expectState("R1", 3'd0);
    expectBit("R1", refreshEn, 1'b1);
    expectBit("R1", dataValid, 1'b0);
    expectBit("R1", busy, 1'b0);

    curReq = "R2";
    writeReq = 1'b1; step(1); writeReq = 1'b0; step(1);
    expectBit("R2", dataValid, 1'b1);

    // low on exactly ENTRY edges: no deep power-down
    curReq = "R3";
    sleepN = 1'b0; step(ENTRY); sleepN = 1'b1; step(2);
    expectState("R3", 3'd0);
    expectBit("R3", dataValid, 1'b1);

    // low on ENTRY+1 edges: deep power-down
    sleepN = 1'b0; step(ENTRY + 1);
    expectState("R3", 3'd2);
    curReq = "R4";
    writeReq = 1'b1; step(3); writeReq = 1'b0;
    expectBit("R4", dataValid, 1'b0);
    expectBit("R4", refreshEn, 1'b0);

    curReq = "R5";
    sleepN = 1'b1; step(1);
    expectState("R5", 3'd3);
    expectBit("R5", busy, 1'b1);
    curReq = "R9";
    sleepN = 1'b0; writeReq = 1'b1; step(INIT - 1);
    expectBit("R9", dataValid, 1'b0);
    writeReq = 1'b0; step(2);
    expectState("R9", 3'd1);
    sleepN = 1'b1; step(2);
    curReq = "R5";
    expectBit("R5", dataValid, 1'b0);
    writeReq = 1'b1; step(1); writeReq = 1'b0; step(1);

    curReq = "R6";
    cfgSleepBit = 1'b1; sleepN = 1'b0; step(3 * ENTRY);
    expectState("R6", 3'd4);
    expectBit("R6", dataValid, 1'b1);
    sleepN = 1'b1; step(1);
    expectState("R6", 3'd0);
    expectBit("R6", busy, 1'b0);

    curReq = "R8";
    cfgSleepBit = 1'b0; sleepN = 1'b0; step(ENTRY / 2);
    cfgSleepBit = 1'b1; step(2 * ENTRY);
    expectState("R8", 3'd4);
    sleepN = 1'b1; cfgSleepBit = 1'b0; step(2);

    curReq = "R2";
    for (int run = 0; run < 250; run++) begin
      int len;
      sleepN = $urandom_range(0, 1);
      len = $urandom_range(1, 2 * ENTRY + 4);
      for (int c = 0; c < len; c++) begin
        if ($urandom_range(0, 29) == 0) cfgSleepBit = ~cfgSleepBit;
        writeReq = ($urandom_range(0, 3) == 0);
        step(1);
      end
    end
    writeReq = 1'b0;

    curReq = "R7";
    sleepN = 1'b1; cfgSleepBit = 1'b0;
    step(INIT + 2);
    writeReq = 1'b1; step(1); writeReq = 1'b0;
    regLoadDone = 1'b1; step(1); regLoadDone = 1'b0; step(2);
    expectState("R7", 3'd4);
    expectBit("R7", accessAllow, 1'b1);
    sleepN = 1'b0; step(3 * ENTRY);
    expectState("R7", 3'd4);
    expectBit("R7", dataValid, 1'b1);
    for (int run = 0; run < 40; run++) begin
      sleepN = $urandom_range(0, 1);
      step($urandom_range(1, 3 * ENTRY));
    end
    expectBit("R7", dataValid, 1'b1);

    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end
endmodule